// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block is the presentation stage of a two-level interrupt controller that sits next to one processor. It keeps a single pending interrupt together with the processor's current priority. It also holds an inter-processor-interrupt request priority, and it drives one interrupt line into the CPU. A separate source stage offers interrupts to it as a source number and a priority. The presenter either takes the offer, or hands the source back with a reject strobe. When the processor's priority relaxes, it asks the source stage to offer rejected sources again.

The processor talks to the block through a command port. A command can change the current priority, write the inter-processor-interrupt priority, accept the pending interrupt, signal end-of-interrupt, or read the state without side effects. Lower priority numbers are more favored. The value 0xFF stands for "nothing pending" or "least favored". The 32-bit state word carries the current priority in bits 31:24 and the pending source number in bits 23:0; source number 0 means none is pending. Every reaction is registered and appears on the outputs one clock after the command or offer.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset the state word reads 0x00000000, the pending priority and the inter-processor-interrupt priority are both 0xFF, the interrupt line is low and no strobe is active.
- R2: Command op 2 (accept) returns the whole state word on rsp_data with rsp_valid for one cycle and lowers the line. The state word then becomes {old pending priority, 24'h0}, and the pending priority becomes 0xFF.
- R3: An offer with priority p is refused when p >= current priority, or when a source is pending whose pending priority <= p. A refused offer produces a reject strobe carrying the offered number and changes no state. Offers carry a nonzero source number and never arrive in a cycle with a command.
- R4: An offer that is not refused first rejects any source already pending. It then latches the new number into bits 23:0, sets the pending priority to p and raises the line.
- R5: Command op 1 writes the inter-processor-interrupt priority from cmd_data[7:0]. If the new value is below the current priority, an inter-processor-interrupt check runs. The check rejects any pending source, loads source number 2, sets the pending priority to the written value and raises the line.
- R6: The inter-processor-interrupt check leaves all state alone when a source is pending whose pending priority <= the inter-processor-interrupt priority.
- R7: Command op 3 (end-of-interrupt) takes cmd_data[31:24] as the new current priority and strobes eoi_valid with cmd_data[23:0]. It then performs a resend.
- R8: Command op 0 with a value below the current priority sets the current priority. If a source is pending with pending priority >= the new value, the source field clears, the pending priority becomes 0xFF, the line falls and the old source is rejected.
- R9: Command op 0 with a value equal to or above the current priority sets it and performs a resend. A resend runs the inter-processor-interrupt check when that priority is below the current priority, and always pulses resend_req for one cycle.
- R10: Command op 4 (poll) returns the state word on rsp_data with rsp_valid. It leaves the state and the line unchanged.
- R11: Command op codes 5 to 7 have no effect on state, line or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 priority, 1 IPI priority, 2 accept, 3 end-of-interrupt, 4 poll) |
| cmd_data | input | 32 | Command operand |
| src_valid | input | 1 | Source stage offers an interrupt |
| src_num | input | 24 | Offered source number |
| src_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt line to the CPU |
| rsp_valid | output | 1 | Response word valid (accept, poll) |
| rsp_data | output | 32 | Response word |
| rej_valid | output | 1 | Reject strobe to the source stage |
| rej_num | output | 24 | Rejected source number |
| resend_req | output | 1 | Request to re-offer rejected sources |
| eoi_valid | output | 1 | End-of-interrupt strobe to the source stage |
| eoi_num | output | 24 | Source number that ended |

## Verification
On every cycle, the assertions check four things. The line must follow a nonzero source field, and an empty source field must pair with priority 0xFF. Accept, end-of-interrupt, poll and unused op codes must each produce their fixed one-cycle effects, and a refused offer must leave the state alone and bounce back its number. Which of several sources survives a sequence of offers, whether the inter-processor-interrupt check fires or holds off, and the exact words returned after priority changes depend on order and history, so only the bench's scenarios can show them.

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [PRIO_W+SRC_W-1:0]   cmd_data,
  input  logic                      src_valid,
  input  logic [SRC_W-1:0]          src_num,
  input  logic [PRIO_W-1:0]         src_prio,
  output logic                      irq_out,
  output logic                      rsp_valid,
  output logic [PRIO_W+SRC_W-1:0]   rsp_data,
  output logic                      rej_valid,
  output logic [SRC_W-1:0]          rej_num,
  output logic                      resend_req,
  output logic                      eoi_valid,
  output logic [SRC_W-1:0]          eoi_num
);
  localparam int REG_W = PRIO_W + SRC_W;
  localparam logic [SRC_W-1:0]  IPI_NUM  = SRC_W'(IPI_SRC);
  localparam logic [PRIO_W-1:0] LEAST    = '1;
  localparam logic [2:0] OP_CPPR = 3'd0, OP_IPI = 3'd1, OP_ACC = 3'd2,
                         OP_EOI  = 3'd3, OP_POLL = 3'd4;

  logic [PRIO_W-1:0] cppr, pend, mfrr;
  logic [SRC_W-1:0]  xisr;

  logic [PRIO_W-1:0] n_cppr, n_pend, n_mfrr;
  logic [SRC_W-1:0]  n_xisr, n_rej_num, n_eoi_num;
  logic [REG_W-1:0]  n_rsp;
  logic              n_irq, n_rej, n_resend, n_eoi, n_rsp_v, do_ipi;

  wire [PRIO_W-1:0] op_prio = cmd_data[REG_W-1 -: PRIO_W];
  wire [SRC_W-1:0]  op_src  = cmd_data[SRC_W-1:0];
  wire [PRIO_W-1:0] op_low  = cmd_data[PRIO_W-1:0];

  always_comb begin
    n_cppr = cppr; n_pend = pend; n_mfrr = mfrr; n_xisr = xisr;
    n_irq = irq_out; n_rej = 1'b0; n_rej_num = '0; n_resend = 1'b0;
    n_eoi = 1'b0; n_eoi_num = '0; n_rsp_v = 1'b0; n_rsp = rsp_data;
    do_ipi = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_CPPR: begin
          n_cppr = op_prio_low();
          if (op_low < cppr) begin
            if (xisr != '0 && op_low <= pend) begin
              n_xisr = '0; n_pend = LEAST; n_irq = 1'b0;
              n_rej = 1'b1; n_rej_num = xisr;
            end
          end else begin
            n_resend = 1'b1;
            do_ipi = (mfrr < op_low);
          end
        end
        OP_IPI: begin
          n_mfrr = op_low;
          do_ipi = (op_low < cppr);
        end
        OP_ACC: begin
          n_rsp_v = 1'b1; n_rsp = {cppr, xisr};
          n_irq = 1'b0; n_cppr = pend; n_xisr = '0; n_pend = LEAST;
        end
        OP_EOI: begin
          n_cppr = op_prio;
          n_eoi = 1'b1; n_eoi_num = op_src;
          n_resend = 1'b1;
          do_ipi = (mfrr < op_prio);
        end
        OP_POLL: begin
          n_rsp_v = 1'b1; n_rsp = {cppr, xisr};
        end
        default: ;
      endcase
    end else if (src_valid) begin
      if (src_prio >= cppr || (xisr != '0 && pend <= src_prio)) begin
        n_rej = 1'b1; n_rej_num = src_num;
      end else begin
        if (xisr != '0) begin
          n_rej = 1'b1; n_rej_num = xisr;
        end
        n_xisr = src_num; n_pend = src_prio; n_irq = 1'b1;
      end
    end
    if (do_ipi && !(n_xisr != '0 && n_pend <= n_mfrr)) begin
      if (n_xisr != '0) begin
        n_rej = 1'b1; n_rej_num = n_xisr;
      end
      n_xisr = IPI_NUM; n_pend = n_mfrr; n_irq = 1'b1;
    end
  end

  function automatic logic [PRIO_W-1:0] op_prio_low();
    return cmd_data[PRIO_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr <= '0; xisr <= '0; pend <= LEAST; mfrr <= LEAST;
      irq_out <= 1'b0; rsp_valid <= 1'b0; rsp_data <= '0;
      rej_valid <= 1'b0; rej_num <= '0; resend_req <= 1'b0;
      eoi_valid <= 1'b0; eoi_num <= '0;
    end else begin
      cppr <= n_cppr; xisr <= n_xisr; pend <= n_pend; mfrr <= n_mfrr;
      irq_out <= n_irq; rsp_valid <= n_rsp_v; rsp_data <= n_rsp;
      rej_valid <= n_rej; rej_num <= n_rej_num; resend_req <= n_resend;
      eoi_valid <= n_eoi; eoi_num <= n_eoi_num;
    end
  end
endmodule

module cpu_irq_presenter_chk #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic [2:0]               cmd_op,
  input logic [PRIO_W+SRC_W-1:0]  cmd_data,
  input logic                     src_valid,
  input logic [SRC_W-1:0]         src_num,
  input logic [PRIO_W-1:0]        src_prio,
  input logic                     irq_out,
  input logic                     rsp_valid,
  input logic                     rej_valid,
  input logic [SRC_W-1:0]         rej_num,
  input logic                     resend_req,
  input logic                     eoi_valid,
  input logic [SRC_W-1:0]         eoi_num,
  input logic [PRIO_W-1:0]        cppr,
  input logic [PRIO_W-1:0]        pend,
  input logic [SRC_W-1:0]         xisr
);
  localparam int REG_W = PRIO_W + SRC_W;

  assert_line_follows_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr != '0));

  assert_empty_least_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xisr == '0) |-> (pend == '1));

  assert_accept_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> (!irq_out && rsp_valid && xisr == '0 && pend == '1));

  assert_eoi_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3) |=> (eoi_valid && resend_req &&
      eoi_num == $past(cmd_data[SRC_W-1:0]) && cppr == $past(cmd_data[REG_W-1 -: PRIO_W])));

  assert_refuse_bounce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !cmd_valid && src_prio >= cppr) |=>
      (rej_valid && rej_num == $past(src_num) && $stable(xisr) && $stable(pend)));

  assert_no_collision_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && src_valid));

  assert_poll_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=>
      ($stable(xisr) && $stable(cppr) && $stable(pend) && $stable(irq_out) && rsp_valid));

  assert_unused_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op > 3'd4) |=>
      ($stable(xisr) && $stable(cppr) && $stable(irq_out) && !rsp_valid && !rej_valid &&
       !resend_req && !eoi_valid));
endmodule

bind cpu_irq_presenter cpu_irq_presenter_chk #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
  .src_valid(src_valid), .src_num(src_num), .src_prio(src_prio), .irq_out(irq_out),
  .rsp_valid(rsp_valid), .rej_valid(rej_valid), .rej_num(rej_num),
  .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
  .cppr(cppr), .pend(pend), .xisr(xisr));

// File: tb/sim_cpu_irq_presenter.sv
module sim_cpu_irq_presenter;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, src_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic [23:0] src_num = '0;
  logic [7:0] src_prio = '0;
  logic irq_out, rsp_valid, rej_valid, resend_req, eoi_valid;
  logic [31:0] rsp_data;
  logic [23:0] rej_num, eoi_num;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_irq_presenter u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .src_valid(src_valid), .src_num(src_num), .src_prio(src_prio), .irq_out(irq_out),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rej_valid(rej_valid), .rej_num(rej_num),
    .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_num(eoi_num));

  typedef struct {
    string       req;
    logic        rsp_v;
    logic [31:0] rsp;
    logic        irq;
    logic        rej_v;
    logic [23:0] rej_n;
    logic        rs;
    logic        eoi_v;
    logic [23:0] eoi_n;
  } exp_t;

  exp_t sb[$];
  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0]  m_cppr = 8'h00, m_pend = 8'hFF, m_mfrr = 8'hFF;
  logic [23:0] m_xisr = '0;
  logic        m_irq = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "irq_out", 32'(irq_out), 32'(e.irq));
      chk(e.req, "rsp_valid", 32'(rsp_valid), 32'(e.rsp_v));
      if (e.rsp_v) chk(e.req, "rsp_data", rsp_data, e.rsp);
      chk(e.req, "rej_valid", 32'(rej_valid), 32'(e.rej_v));
      if (e.rej_v) chk(e.req, "rej_num", 32'(rej_num), 32'(e.rej_n));
      chk(e.req, "resend_req", 32'(resend_req), 32'(e.rs));
      chk(e.req, "eoi_valid", 32'(eoi_valid), 32'(e.eoi_v));
      if (e.eoi_v) chk(e.req, "eoi_num", 32'(eoi_num), 32'(e.eoi_n));
    end
  end

  task automatic ipi_check(inout exp_t e);
    if (!(m_xisr != 0 && m_pend <= m_mfrr)) begin
      if (m_xisr != 0) begin e.rej_v = 1; e.rej_n = m_xisr; end
      m_xisr = 24'd2; m_pend = m_mfrr; m_irq = 1;
    end
  endtask

  task automatic issue(string req, bit is_cmd, logic [2:0] op, logic [31:0] d,
                       logic [23:0] n, logic [7:0] p);
    exp_t e;
    e.req = req; e.rsp_v = 0; e.rsp = 0; e.rej_v = 0; e.rej_n = 0;
    e.rs = 0; e.eoi_v = 0; e.eoi_n = 0;
    if (!is_cmd) begin
      if (p >= m_cppr || (m_xisr != 0 && m_pend <= p)) begin
        e.rej_v = 1; e.rej_n = n;
      end else begin
        if (m_xisr != 0) begin e.rej_v = 1; e.rej_n = m_xisr; end
        m_xisr = n; m_pend = p; m_irq = 1;
      end
    end else begin
      case (op)
        3'd0: begin
          if (d[7:0] < m_cppr) begin
            m_cppr = d[7:0];
            if (m_xisr != 0 && m_cppr <= m_pend) begin
              e.rej_v = 1; e.rej_n = m_xisr; m_xisr = 0; m_pend = 8'hFF; m_irq = 0;
            end
          end else begin
            m_cppr = d[7:0]; e.rs = 1;
            if (m_mfrr < m_cppr) ipi_check(e);
          end
        end
        3'd1: begin m_mfrr = d[7:0]; if (m_mfrr < m_cppr) ipi_check(e); end
        3'd2: begin
          e.rsp_v = 1; e.rsp = {m_cppr, m_xisr};
          m_irq = 0; m_cppr = m_pend; m_xisr = 0; m_pend = 8'hFF;
        end
        3'd3: begin
          m_cppr = d[31:24]; e.eoi_v = 1; e.eoi_n = d[23:0]; e.rs = 1;
          if (m_mfrr < m_cppr) ipi_check(e);
        end
        3'd4: begin e.rsp_v = 1; e.rsp = {m_cppr, m_xisr}; end
        default: ;
      endcase
    end
    e.irq = m_irq;
    @(negedge clk);
    cmd_valid = is_cmd; cmd_op = op; cmd_data = d;
    src_valid = !is_cmd; src_num = n; src_prio = p;
    @(posedge clk);
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 0; src_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R1", "irq_out after reset", 32'(irq_out), 32'd0);
    chk("R1", "strobes after reset", {rsp_valid, rej_valid, resend_req, eoi_valid}, 32'd0);
    issue("R1", 1, 3'd4, 0, 0, 0);                       // poll: word 0
    issue("R3", 0, 0, 0, 24'd5, 8'd3);                   // priority 0 refuses all
    issue("R9", 1, 3'd0, 32'hFF, 0, 0);                  // raise: resend
    issue("R4", 0, 0, 0, 24'd5, 8'd3);                   // taken
    issue("R3", 0, 0, 0, 24'd6, 8'd4);                   // pending more favored
    issue("R4", 0, 0, 0, 24'd7, 8'd1);                   // displaces 5
    issue("R10", 1, 3'd4, 0, 0, 0);                      // poll FF000007
    issue("R10", 1, 3'd4, 0, 0, 0);                      // unchanged
    issue("R6", 1, 3'd1, 32'h2, 0, 0);                   // held off by pending 1
    issue("R2", 1, 3'd2, 0, 0, 0);                       // accept FF000007
    issue("R5", 1, 3'd1, 32'h0, 0, 0);                   // IPI fires
    issue("R2", 1, 3'd2, 0, 0, 0);                       // accept 01000002
    issue("R7", 1, 3'd3, 32'hFF000002, 0, 0);            // eoi, IPI again
    issue("R5", 1, 3'd1, 32'hFF, 0, 0);                  // IPI priority back to FF
    issue("R8", 1, 3'd0, 32'h10, 0, 0);                  // lower, pending 0 stays
    issue("R2", 1, 3'd2, 0, 0, 0);
    issue("R7", 1, 3'd3, 32'hFF000002, 0, 0);
    issue("R4", 0, 0, 0, 24'd9, 8'h20);
    issue("R8", 1, 3'd0, 32'h20, 0, 0);                  // clears and rejects 9
    issue("R11", 1, 3'd6, 32'h0, 0, 0);                  // unused op
    issue("R11", 1, 3'd4, 0, 0, 0);                      // poll 20000000
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule